// File: doc/BRIEF.md
# One-Shot and Periodic Tick Timers

This block holds two 32-bit timers that count pulses of a tick-enable input. A byte-addressed register window with word-only access reaches both. One timer is a one-shot: it fires once and then falls idle. The other is periodic: after each expiry it starts the same interval again. Each timer raises a single-cycle pulse on its own output when it expires.

Software programs a timer by writing an interval to that timer's control word. A write of zero stops the timer. A nonzero value arms it, and timing restarts from the write. The control word reads back the interval that was written last. A separate read-only word reports how many ticks remain. All data on the bus is big-endian: the byte lane for the lowest address carries the most significant byte.

The bus access is combinational. Read data and the error flag are valid in the same cycle as the request. A write takes effect at the next clock edge.

Top module: `tick_timer_pair`

## Requirements
- R1: Only 32-bit aligned accesses are legal. A request flags `rsp_err` in the same cycle in any of these cases: `req_size` is not 4, the address is not word aligned, or the address is none of 0x20 (one-shot control), 0x24 (one-shot remaining), 0x28 (periodic control) or 0x2C (periodic remaining). A write to a remaining word is also an error. A request that errors changes no timer state and reads as zero.
- R2: Data is big-endian on the bus. Byte lane k (bits 8k+7..8k) of `req_wdata` and `rsp_rdata` holds the byte at address offset k. Offset 0 is the most significant byte of the 32-bit value.
- R3: Writing 0 to a control word disarms that timer. Its remaining word then reads 0 and it produces no further pulses.
- R4: Writing a nonzero N to a control word arms the timer. The remaining word reads N in the cycle after the write and drops by one on each cycle with `tick_en` high. The timer fires in the cycle of the Nth tick after the write.
- R5: A control write to a timer that is already armed cancels the pending expiry and restarts the count from the new value.
- R6: A control word reads back the value written to it last, including after its timer has expired.
- R7: The one-shot pulses `oneshot_fire` once at expiry. It then reads remaining 0 and does not fire again until it is written.
- R8: The periodic timer pulses `periodic_fire` at expiry and reloads the same interval, so it fires on every Nth tick. An interval of 1 fires on every tick.
- R9: A fire output is high only in a cycle where `tick_en` is high. When ticks are spaced out, the fire output is a single-cycle pulse.
- R10: After reset both timers are disarmed, and all four words read 0.
- R11: When a control write and a tick fall in the same cycle, the write takes priority. That tick is not counted against the new interval, and it raises no fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One tick per cycle while high |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Byte address within the window |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, byte lanes in address order |
| rsp_rdata | output | 32 | Read data, byte lanes in address order |
| rsp_err | output | 1 | Illegal access flag |
| oneshot_fire | output | 1 | One-shot expiry pulse |
| periodic_fire | output | 1 | Periodic expiry pulse |

## Verification
Ticks are applied in three patterns: continuously, with irregular gaps, and with a tick in the same cycle as a control write. The continuous pattern tells an off-by-one expiry apart from a correct one. The gaps show that only tick cycles count and that pulses last one cycle. The coinciding pattern shows that the write takes priority. A byte pattern with four distinct bytes exposes any swapped lane order. Illegal sizes, misaligned addresses and writes to read-only words are each followed by read-backs, which show that nothing changed. Rewrites in the middle of a count, zero writes, and intervals of 1 cover restart, cancel and the shortest period.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int WORD_W = 32;

  localparam int OS_CTL_OFS  = 'h20;
  localparam int OS_REM_OFS  = 'h24;
  localparam int PER_CTL_OFS = 'h28;
  localparam int PER_REM_OFS = 'h2C;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_OS_CTL, SEL_OS_REM, SEL_PER_CTL, SEL_PER_REM
  } rd_sel_e;

  // Reverse byte lanes: bus lane order <-> big-endian value.
  function automatic logic [WORD_W-1:0] lane_swap(input logic [WORD_W-1:0] x);
    logic [WORD_W-1:0] y;
    for (int b = 0; b < WORD_W/8; b++)
      y[8*b +: 8] = x[WORD_W-8-8*b +: 8];
    return y;
  endfunction

  // Remaining count after one tick of an armed timer.
  function automatic logic [WORD_W-1:0] after_tick(input logic [WORD_W-1:0] rem,
                                                   input logic [WORD_W-1:0] interval,
                                                   input logic periodic);
    if (rem == 1) return periodic ? interval : '0;
    return rem - 1'b1;
  endfunction
endpackage

// File: rtl/tt_decode.sv
module tt_decode
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int SIZE_W = 3
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  output logic [1:0]        ctl_load,
  output rd_sel_e           rd_sel,
  output logic              err
);
  localparam int BYTES = WORD_W / 8;

  logic    word_ok;
  rd_sel_e hit;
  logic    legal;

  assign word_ok = (int'(req_size) == BYTES) && (req_addr[1:0] == 2'b00);

  always_comb begin
    hit = SEL_NONE;
    case (int'(req_addr))
      OS_CTL_OFS:  hit = SEL_OS_CTL;
      OS_REM_OFS:  hit = SEL_OS_REM;
      PER_CTL_OFS: hit = SEL_PER_CTL;
      PER_REM_OFS: hit = SEL_PER_REM;
      default:     hit = SEL_NONE;
    endcase
  end

  assign legal = word_ok && (hit != SEL_NONE) &&
                 (!req_write || hit == SEL_OS_CTL || hit == SEL_PER_CTL);

  assign err         = req_valid && !legal;
  assign ctl_load[0] = req_valid && legal && req_write && (hit == SEL_OS_CTL);
  assign ctl_load[1] = req_valid && legal && req_write && (hit == SEL_PER_CTL);
  assign rd_sel      = (req_valid && legal && !req_write) ? hit : SEL_NONE;
endmodule

// File: rtl/tt_counter.sv
module tt_counter
  import tick_timer_pkg::*;
#(
  parameter int W        = WORD_W,
  parameter bit PERIODIC = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] interval,
  output logic [W-1:0] remaining,
  output logic         fire
);
  logic [W-1:0] ctl_q, rem_q;
  logic         armed, tick_hit;

  assign armed    = (rem_q != '0);
  assign tick_hit = tick_en && armed && !load;
  assign fire     = tick_hit && (rem_q == 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      rem_q <= '0;
    end else if (load) begin
      ctl_q <= load_val;
      rem_q <= load_val;
    end else if (tick_hit) begin
      rem_q <= after_tick(rem_q, ctl_q, PERIODIC);
    end
  end

  assign interval  = ctl_q;
  assign remaining = rem_q;

  p_load_restarts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (rem_q == $past(load_val)) && (ctl_q == $past(load_val)));

  p_fire_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> tick_en && !load);

  p_idle_no_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_q == '0) |-> !fire);

  p_expiry_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (rem_q == (PERIODIC ? $past(ctl_q) : '0)));

  p_ctl_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(ctl_q));
endmodule

// File: rtl/tick_timer_pair.sv
module tick_timer_pair
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int SIZE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [WORD_W-1:0] req_wdata,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              oneshot_fire,
  output logic              periodic_fire
);
  localparam int NT = 2;

  logic [NT-1:0]     ctl_load;
  logic [NT-1:0]     fire;
  logic [WORD_W-1:0] ivl [NT];
  logic [WORD_W-1:0] rem [NT];
  logic [WORD_W-1:0] wval, rval;
  rd_sel_e           rd_sel;

  tt_decode #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_dec (
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .ctl_load(ctl_load), .rd_sel(rd_sel), .err(rsp_err)
  );

  assign wval = lane_swap(req_wdata);

  for (genvar g = 0; g < NT; g++) begin : g_tmr
    tt_counter #(.W(WORD_W), .PERIODIC(g == 1)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load(ctl_load[g]),
      .load_val(wval), .interval(ivl[g]), .remaining(rem[g]), .fire(fire[g])
    );
  end

  always_comb begin
    case (rd_sel)
      SEL_OS_CTL:  rval = ivl[0];
      SEL_OS_REM:  rval = rem[0];
      SEL_PER_CTL: rval = ivl[1];
      SEL_PER_REM: rval = rem[1];
      default:     rval = '0;
    endcase
  end

  assign rsp_rdata     = lane_swap(rval);
  assign oneshot_fire  = fire[0];
  assign periodic_fire = fire[1];

  p_err_blocks_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (ctl_load == '0) && (rsp_rdata == '0));

  p_single_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctl_load));
endmodule

// File: tb/tick_timer_pair_bench.sv
module tick_timer_pair_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [2:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        rsp_err, oneshot_fire, periodic_fire;

  int checks = 0, errors = 0;
  bit done = 0;

  longint m_ctl [2];
  longint m_rem [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_timer_pair u_tick_timer_pair (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .oneshot_fire(oneshot_fire), .periodic_fire(periodic_fire)
  );

  // Big-endian value -> lane order, written independently of the RTL.
  function automatic logic [31:0] to_lanes(input longint v);
    logic [31:0] x;
    x = v[31:0];
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // One clock cycle: drive, compare against the model at negedge, advance model.
  task automatic step(input string tag, input bit v, input bit w, input int a,
                      input int sz, input longint val, input bit tk);
    bit ok, ld0, ld1;
    longint exp_rd;
    bit fire_exp [2];
    req_valid = v; req_write = w; req_addr = a[5:0]; req_size = sz[2:0];
    req_wdata = to_lanes(val); tick_en = tk;
    ok = (sz == 4) && (a == 'h20 || a == 'h28 || (!w && (a == 'h24 || a == 'h2C)));
    ld0 = v && ok && w && a == 'h20;
    ld1 = v && ok && w && a == 'h28;
    exp_rd = 0;
    if (v && ok && !w) begin
      if (a == 'h20) exp_rd = m_ctl[0];
      if (a == 'h24) exp_rd = m_rem[0];
      if (a == 'h28) exp_rd = m_ctl[1];
      if (a == 'h2C) exp_rd = m_rem[1];
    end
    fire_exp[0] = tk && m_rem[0] == 1 && !ld0;
    fire_exp[1] = tk && m_rem[1] == 1 && !ld1;
    @(negedge clk);
    check(tag, "err", rsp_err, v && !ok);
    check(tag, "rdata", rsp_rdata, to_lanes(exp_rd));
    check(tag, "oneshot_fire", oneshot_fire, fire_exp[0]);
    check(tag, "periodic_fire", periodic_fire, fire_exp[1]);
    @(posedge clk);
    for (int k = 0; k < 2; k++) begin
      if ((k == 0 && ld0) || (k == 1 && ld1)) begin
        m_ctl[k] = val & 64'hFFFF_FFFF;
        m_rem[k] = m_ctl[k];
      end else if (tk && m_rem[k] != 0) begin
        if (m_rem[k] == 1) m_rem[k] = (k == 1) ? m_ctl[k] : 0;
        else m_rem[k] = m_rem[k] - 1;
      end
    end
    #1;
  endtask

  task automatic idle(input string tag, input int n, input bit tk);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 4, 0, tk);
  endtask

  task automatic rd(input string tag, input int a, input bit tk);
    step(tag, 1, 0, a, 4, 0, tk);
  endtask

  task automatic wr(input string tag, input int a, input longint val, input bit tk);
    step(tag, 1, 1, a, 4, val, tk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) begin m_ctl[k] = 0; m_rem[k] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10: reset state of all four words
    rd("R10", 'h20, 0); rd("R10", 'h24, 0); rd("R10", 'h28, 0); rd("R10", 'h2C, 0);

    // R1: illegal sizes, misaligned, unknown, writes to remaining words
    step("R1", 1, 1, 'h20, 2, 7, 0);
    step("R1", 1, 1, 'h21, 4, 7, 0);
    step("R1", 1, 1, 'h24, 4, 7, 0);
    step("R1", 1, 0, 'h28, 1, 0, 0);
    step("R1", 1, 1, 'h10, 4, 7, 0);
    rd("R1", 'h20, 0); rd("R1", 'h24, 0); rd("R1", 'h28, 0);

    // R2: distinct byte pattern through control and remaining words
    wr("R2", 'h28, 'h0102_0304, 0);
    rd("R2", 'h28, 0); rd("R2", 'h2C, 0);
    wr("R3", 'h28, 0, 1);
    rd("R3", 'h2C, 1); idle("R3", 3, 1);

    // R4 / R7: one-shot with continuous ticks
    wr("R4", 'h20, 5, 0);
    rd("R4", 'h24, 0);
    for (int i = 0; i < 7; i++) rd("R7", 'h24, 1);
    rd("R6", 'h20, 1);
    idle("R7", 4, 1);

    // R9: one-shot with irregular tick gaps
    wr("R9", 'h20, 3, 0);
    step("R9", 0, 0, 0, 4, 0, 1); idle("R9", 2, 0);
    step("R9", 0, 0, 0, 4, 0, 1); idle("R9", 1, 0);
    step("R9", 0, 0, 0, 4, 0, 1); idle("R9", 3, 0);
    rd("R7", 'h24, 0);

    // R8: periodic interval 3 over several periods, with gaps
    wr("R8", 'h28, 3, 0);
    for (int i = 0; i < 10; i++) rd("R8", 'h2C, 1);
    for (int i = 0; i < 8; i++) rd("R8", 'h2C, i[0]);
    // R8: interval 1 fires every tick
    wr("R8", 'h28, 1, 0);
    idle("R8", 5, 1);

    // R5: rewrite mid-count restarts
    wr("R5", 'h28, 6, 0);
    idle("R5", 3, 1);
    wr("R5", 'h28, 4, 0);
    for (int i = 0; i < 6; i++) rd("R5", 'h2C, 1);

    // R11: write coinciding with a tick, including at the expiry tick
    wr("R11", 'h20, 2, 1);
    step("R11", 0, 0, 0, 4, 0, 1);
    wr("R11", 'h20, 2, 1);
    rd("R11", 'h24, 1); rd("R11", 'h24, 1); rd("R11", 'h24, 1);

    // R3: zero write cancels an armed periodic timer
    wr("R3", 'h28, 2, 0);
    idle("R3", 1, 1);
    wr("R3", 'h28, 0, 1);
    rd("R3", 'h2C, 1); idle("R3", 4, 1);
    rd("R6", 'h28, 0);

    // R6: large value readback after expiry and restart
    wr("R6", 'h20, 'hFFFF_FFFF, 1);
    rd("R6", 'h20, 1); rd("R6", 'h24, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule